// File: doc/BRIEF.md
# Sample Queue Serial Port with Defined Partial Transfers

This block holds conversion results in a queue and keeps a small bank of configuration registers. Both are reached through a four-wire serial slave. Each queue entry is a 16-bit word sent most significant bit first. The top 4 bits of each word are always zero and the low 12 bits are the stored sample. Configuration registers are loaded most significant bit first. The serial inputs are sampled and synchronised on the system clock. A frame is one chip-select low period, and its first byte on the data input is a command.

The block spells out what happens when chip select rises in the middle of a byte. The read cursor of the head entry survives across frames. A read that stops partway through the first byte narrows the entry to one more byte. A read that stops partway through the second byte throws away the rest of the entry. A register write that stops early updates only the bits already shifted in. If a frame opens while a conversion is still running, a sticky corrupt flag is set.

Top module: `rdq_serial_port`

## Requirements
- R1: A frame whose command byte matches 01xxxxxx streams queue entries back to back. Each entry is sent as 16 bits, MSB first, with the 4 top bits zero. An entry leaves the queue after its 16th bit. The master samples `spi_mosi` and `spi_miso` just before each rising edge of `spi_sclk`.
- R2: A command byte matching 1xxxxxii loads register ii from the next 8 bits, MSB first. Further bits in the same frame are ignored.
- R3: If a register write stops after k bits (k from 0 to 7), the top k bits take the new values and the lower bits keep their old contents.
- R4: Suppose a frame ends after k bits of an entry's first byte, with k from 1 to 7. The next read then returns 8 bits, which are word bits 15-k down to 8-k. The entry is then dropped and the next entry follows directly.
- R5: If a frame ends after 9 to 15 bits of an entry, the rest of that entry is dropped. Later entries are read intact.
- R6: If a frame ends after exactly 8 bits of an entry, the entry is kept. The next read starts with its low byte.
- R7: Reading an empty queue sends zeros and leaves the cursor unchanged. An entry pushed later is read from its first bit.
- R8: A push is accepted when the queue is not full, or when an entry leaves in the same cycle. Otherwise it is dropped. `fifo_count` follows every push and removal.
- R9: If chip select falls while `conv_idle` is low, `fifo_corrupt` is set. It stays set through later frames.
- R10: A command byte matching 001xxxxx empties the queue, rewinds the cursor and clears `fifo_corrupt`.
- R11: After reset the queue is empty and the count is 0. `spi_miso`, `fifo_corrupt`, `fifo_full` and all registers are 0.
- R12: A command byte matching 000xxxxx has no effect for the rest of its frame. `spi_miso` stays 0, and the queue, the cursor and the registers are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Frame select, active low |
| spi_sclk | input | 1 | Serial clock, idles low |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out of the block |
| push_valid | input | 1 | Push a new sample this cycle |
| push_data | input | 12 | Sample to push |
| conv_idle | input | 1 | High when no conversion is in flight |
| fifo_count | output | $clog2(DEPTH+1) | Number of stored entries |
| fifo_empty | output | 1 | Queue holds no entry |
| fifo_full | output | 1 | Queue holds DEPTH entries |
| fifo_corrupt | output | 1 | Sticky corruption flag |
| cfg_regs | output | NREG*REG_W | Register bank, register g at bits g*REG_W upward |

## Verification
A push and a removal can land on the same clock edge. On a full queue this is the one case where the push must still be taken. The bench fills a four-entry queue and then holds `push_valid` high with a fixed sample for a whole 16-bit read. The removal edge therefore always meets a waiting push, whatever the synchroniser delay. The test passes if the queue is full again afterwards and the fixed sample comes out last, behind the three older entries. A checker ties every per-cycle count change to the accepted pushes and removals.

// File: rtl/rdq_pkg.sv
package rdq_pkg;
  localparam int WORD_W   = 16;
  localparam int PAD_W    = 4;
  localparam int SAMPLE_W = WORD_W - PAD_W;
  localparam int POS_W    = 4;

  typedef enum logic [1:0] {PH_IDLE, PH_CMD, PH_WREG, PH_READ} phase_e;
  typedef enum logic [1:0] {OP_NONE, OP_WRITE, OP_READ, OP_CLEAR} op_e;

  // command byte: top set bit selects the operation
  function automatic op_e decode_op(input logic [7:0] c);
    if (c[7])      return OP_WRITE;
    else if (c[6]) return OP_READ;
    else if (c[5]) return OP_CLEAR;
    else           return OP_NONE;
  endfunction

  function automatic logic [WORD_W-1:0] pad_word(input logic [SAMPLE_W-1:0] s);
    return {{PAD_W{1'b0}}, s};
  endfunction

  function automatic logic bit_at(input logic [WORD_W-1:0] w, input logic [POS_W-1:0] p);
    return w[POS_W'(WORD_W-1) - p];
  endfunction

  // last cursor position of the current entry before it leaves the queue
  function automatic logic [POS_W-1:0] last_pos(input logic narrow, input logic [POS_W-1:0] start);
    return narrow ? start + POS_W'(7) : POS_W'(WORD_W-1);
  endfunction

  // frame end inside the second byte (or inside the narrowed byte) drops the entry
  function automatic logic drop_on_end(input logic narrow, input logic [POS_W-1:0] pos,
                                       input logic [POS_W-1:0] start);
    if (narrow) return pos != start;
    return pos > POS_W'(8);
  endfunction

  // frame end inside the first byte narrows the entry to one more byte
  function automatic logic narrow_on_end(input logic narrow, input logic [POS_W-1:0] pos);
    return !narrow && (pos != '0) && (pos < POS_W'(8));
  endfunction

  // write bit n of a register loaded MSB first
  function automatic logic [31:0] msb_mask(input int width, input int n);
    return (32'd1 << (width - 1)) >> n;
  endfunction
endpackage

// File: rtl/rdq_sync.sv
module rdq_sync #(
  parameter int             W    = 1,
  parameter logic [W-1:0]   INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= INIT;
      q      <= INIT;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/rdq_fifo.sv
module rdq_fifo
  import rdq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                push_valid,
  input  logic [SAMPLE_W-1:0] push_data,
  input  logic                pop,
  input  logic                corrupt_set,
  output logic                push_ok,
  output logic [WORD_W-1:0]   head,
  output logic [CNT_W-1:0]    count,
  output logic                empty,
  output logic                full,
  output logic                corrupt
);
  logic [SAMPLE_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]    wp, rp;
  logic                pop_ok;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CNT_W'(DEPTH));
  assign pop_ok  = pop && !empty;
  assign push_ok = push_valid && !clr && (!full || pop_ok);
  assign head    = pad_word(mem[rp]);

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else if (clr) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push_ok) wp <= step(wp);
      if (pop_ok)  rp <= step(rp);
      unique case ({push_ok, pop_ok})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           corrupt <= 1'b0;
    else if (corrupt_set) corrupt <= 1'b1;
    else if (clr)         corrupt <= 1'b0;
  end
endmodule

// File: rtl/rdq_cursor.sv
module rdq_cursor
  import rdq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic             frame_end,
  input  logic             avail,
  output logic [POS_W-1:0] pos,
  output logic             pop
);
  logic             narrow;
  logic [POS_W-1:0] start;
  logic             at_last;

  assign at_last = (pos == last_pos(narrow, start));
  assign pop     = (adv && at_last) ||
                   (frame_end && avail && drop_on_end(narrow, pos, start));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos    <= '0;
      narrow <= 1'b0;
      start  <= '0;
    end else if (clr || pop) begin
      pos    <= '0;
      narrow <= 1'b0;
      start  <= '0;
    end else if (adv) begin
      pos <= pos + POS_W'(1);
    end else if (frame_end && narrow_on_end(narrow, pos)) begin
      narrow <= 1'b1;
      start  <= pos;
    end
  end
endmodule

// File: rtl/rdq_serial_port.sv
module rdq_serial_port
  import rdq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int NREG  = 4,
  parameter int REG_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  spi_cs_n,
  input  logic                  spi_sclk,
  input  logic                  spi_mosi,
  output logic                  spi_miso,
  input  logic                  push_valid,
  input  logic [SAMPLE_W-1:0]   push_data,
  input  logic                  conv_idle,
  output logic [CNT_W-1:0]      fifo_count,
  output logic                  fifo_empty,
  output logic                  fifo_full,
  output logic                  fifo_corrupt,
  output logic [NREG*REG_W-1:0] cfg_regs
);
  localparam int BC_W  = $clog2(((REG_W > 8) ? REG_W : 8) + 1);
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

  // synchronised serial pins and their edges
  logic [2:0] sync_q;
  logic       cs_n_s, sclk_s, mosi_s, cs_n_d, sclk_d;
  logic       cs_fall, cs_rise, sclk_rise;

  rdq_sync #(.W(3), .INIT(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({spi_cs_n, spi_sclk, spi_mosi}),
    .q     (sync_q)
  );

  assign cs_n_s = sync_q[2];
  assign sclk_s = sync_q[1];
  assign mosi_s = sync_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n_d <= 1'b1;
      sclk_d <= 1'b0;
    end else begin
      cs_n_d <= cs_n_s;
      sclk_d <= sclk_s;
    end
  end

  assign cs_fall   = cs_n_d && !cs_n_s;
  assign cs_rise   = !cs_n_d && cs_n_s;
  assign sclk_rise = !sclk_d && sclk_s && !cs_n_s;

  // frame state
  phase_e           phase;
  logic [6:0]       cmd_sr;
  logic [BC_W-1:0]  bit_cnt;
  logic [IDX_W-1:0] widx;
  logic [7:0]       cmd_byte;
  op_e              op_now;
  logic             cmd_done;

  // named internal events
  logic             bit_adv, entry_pop, push_ok, clr_cmd, corrupt_set, reg_bit_we;
  logic [POS_W-1:0] rd_pos;
  logic [WORD_W-1:0] head;

  assign cmd_byte    = {cmd_sr, mosi_s};
  assign op_now      = decode_op(cmd_byte);
  assign cmd_done    = (phase == PH_CMD) && sclk_rise && (bit_cnt == BC_W'(7));
  assign clr_cmd     = cmd_done && (op_now == OP_CLEAR);
  assign bit_adv     = (phase == PH_READ) && sclk_rise && !fifo_empty;
  assign corrupt_set = cs_fall && !conv_idle;
  assign reg_bit_we  = (phase == PH_WREG) && sclk_rise && (bit_cnt < BC_W'(REG_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      cmd_sr  <= '0;
      bit_cnt <= '0;
      widx    <= '0;
    end else if (cs_fall) begin
      phase   <= PH_CMD;
      bit_cnt <= '0;
    end else if (cs_rise) begin
      phase   <= PH_IDLE;
    end else if (sclk_rise) begin
      unique case (phase)
        PH_CMD: begin
          cmd_sr <= cmd_byte[6:0];
          if (bit_cnt == BC_W'(7)) begin
            bit_cnt <= '0;
            unique case (op_now)
              OP_WRITE: begin
                phase <= PH_WREG;
                widx  <= cmd_byte[IDX_W-1:0];
              end
              OP_READ: phase <= PH_READ;
              default: phase <= PH_IDLE;
            endcase
          end else begin
            bit_cnt <= bit_cnt + BC_W'(1);
          end
        end
        PH_WREG: if (reg_bit_we) bit_cnt <= bit_cnt + BC_W'(1);
        default: ;
      endcase
    end
  end

  rdq_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (clr_cmd),
    .push_valid  (push_valid),
    .push_data   (push_data),
    .pop         (entry_pop),
    .corrupt_set (corrupt_set),
    .push_ok     (push_ok),
    .head        (head),
    .count       (fifo_count),
    .empty       (fifo_empty),
    .full        (fifo_full),
    .corrupt     (fifo_corrupt)
  );

  rdq_cursor u_cursor (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr_cmd),
    .adv       (bit_adv),
    .frame_end (cs_rise),
    .avail     (!fifo_empty),
    .pos       (rd_pos),
    .pop       (entry_pop)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) spi_miso <= 1'b0;
    else        spi_miso <= (phase == PH_READ) && !cs_n_s && !fifo_empty && bit_at(head, rd_pos);
  end

  // register bank, loaded MSB first one bit per serial clock
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [REG_W-1:0] r;
    logic [REG_W-1:0] m;
    assign m = REG_W'(msb_mask(REG_W, int'(bit_cnt)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r <= '0;
      else if (reg_bit_we && (widx == IDX_W'(g))) r <= mosi_s ? (r | m) : (r & ~m);
    end
    assign cfg_regs[g*REG_W +: REG_W] = r;
  end
endmodule

// File: rtl/rdq_serial_port_chk.sv
module rdq_serial_port_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] fifo_count,
  input logic             fifo_empty,
  input logic             fifo_full,
  input logic             fifo_corrupt,
  input logic             spi_miso,
  input logic             push_valid,
  input logic             push_ok,
  input logic             entry_pop,
  input logic             clr_cmd,
  input logic             corrupt_set,
  input logic [3:0]       rd_pos
);
  assert_count_track_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_cmd |=> (fifo_count + CNT_W'($past(entry_pop))) == ($past(fifo_count) + CNT_W'($past(push_ok))));

  assert_full_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full && push_valid && !entry_pop && !clr_cmd |=> fifo_full);

  assert_empty_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_empty |=> !spi_miso);

  assert_empty_nopop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_empty |-> !entry_pop);

  assert_pop_rewind_R4: assert property (@(posedge clk) disable iff (!rst_n)
    entry_pop |=> rd_pos == 4'd0);

  assert_corrupt_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    corrupt_set |=> fifo_corrupt);

  assert_corrupt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_corrupt && !clr_cmd |=> fifo_corrupt);

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_cmd && !corrupt_set |=> fifo_empty && !fifo_corrupt && rd_pos == 4'd0);
endmodule

bind rdq_serial_port rdq_serial_port_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .fifo_count   (fifo_count),
  .fifo_empty   (fifo_empty),
  .fifo_full    (fifo_full),
  .fifo_corrupt (fifo_corrupt),
  .spi_miso     (spi_miso),
  .push_valid   (push_valid),
  .push_ok      (push_ok),
  .entry_pop    (entry_pop),
  .clr_cmd      (clr_cmd),
  .corrupt_set  (corrupt_set),
  .rd_pos       (rd_pos)
);

// File: tb/rdq_serial_port_tb.sv
module rdq_serial_port_tb_top;
  localparam int CLK_P = 10;
  localparam int HP    = 4;
  localparam int DEPTH = 4;
  localparam int NREG  = 4;
  localparam int REG_W = 8;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0, miso;
  logic push_valid = 1'b0;
  logic [11:0] push_data = '0;
  logic conv_idle = 1'b1;
  logic [CNT_W-1:0] count;
  logic empty, full, corrupt;
  logic [NREG*REG_W-1:0] regs;
  int total = 0, bad = 0;

  always #(CLK_P/2) clk = ~clk;

  rdq_serial_port #(.DEPTH(DEPTH), .NREG(NREG), .REG_W(REG_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sclk(sclk), .spi_mosi(mosi),
    .spi_miso(miso), .push_valid(push_valid), .push_data(push_data),
    .conv_idle(conv_idle), .fifo_count(count), .fifo_empty(empty),
    .fifo_full(full), .fifo_corrupt(corrupt), .cfg_regs(regs)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] pat(input int k);
    return 12'(k * 12'h159 + 12'h6A3);
  endfunction

  task automatic cs_low();  cs_n = 1'b0; tick(6); endtask
  task automatic cs_high(); sclk = 1'b0; tick(2); cs_n = 1'b1; tick(8); endtask

  task automatic shift(input logic b, output logic o);
    mosi = b; sclk = 1'b0; tick(HP);
    o = miso; sclk = 1'b1; tick(HP);
    sclk = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    logic o;
    for (int i = 7; i >= 0; i--) shift(b[i], o);
  endtask

  task automatic read_bits(input int n, output logic [15:0] r);
    logic o;
    r = '0;
    for (int i = 0; i < n; i++) begin
      shift(1'b0, o);
      r = {r[14:0], o};
    end
  endtask

  task automatic clear_frame();
    cs_low(); send_byte(8'h20); cs_high();
  endtask

  task automatic write_frame(input int idx, input logic [15:0] v, input int nbits);
    logic o;
    cs_low(); send_byte(8'h80 | 8'(idx));
    for (int i = 0; i < nbits; i++) shift(v[15-i], o);
    cs_high();
  endtask

  task automatic push(input logic [11:0] d);
    push_valid = 1'b1; push_data = d; tick(1); push_valid = 1'b0; tick(1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] r, r2, wa, wb;
    logic [7:0]  old_v, new_v, msk;
    logic [NREG*REG_W-1:0] snap;
    tick(5); rst_n = 1'b1; tick(3);

    // R11 reset state
    check("R11 miso", miso, 0);
    check("R11 count", count, 0);
    check("R11 empty/full/corrupt", {empty, full, corrupt}, 3'b100);
    check("R11 regs", regs, 0);

    // R1 streamed read of three entries in one frame
    for (int i = 0; i < 3; i++) push(pat(i));
    check("R1 count after push", count, 3);
    cs_low(); send_byte(8'h40);
    for (int i = 0; i < 3; i++) begin
      read_bits(16, r);
      check("R1 word", r, {4'b0, pat(i)});
    end
    cs_high();
    check("R1 drained", count, 0);

    // R4 partial first byte, every k
    for (int k = 1; k < 8; k++) begin
      clear_frame();
      push(pat(k)); push(pat(k + 20));
      wa = {4'b0, pat(k)}; wb = {4'b0, pat(k + 20)};
      cs_low(); send_byte(8'h40); read_bits(k, r); cs_high();
      check("R4 partial bits", r, wa >> (16 - k));
      check("R4 entry kept", count, 2);
      cs_low(); send_byte(8'h40); read_bits(8, r); read_bits(16, r2); cs_high();
      check("R4 next byte", r, (wa >> (8 - k)) & 16'h00FF);
      check("R4 following entry", r2, wb);
      check("R4 count", count, 0);
    end

    // R5 partial second byte, every m
    for (int m = 9; m < 16; m++) begin
      clear_frame();
      push(pat(m)); push(pat(m + 30));
      wa = {4'b0, pat(m)}; wb = {4'b0, pat(m + 30)};
      cs_low(); send_byte(8'h40); read_bits(m, r); cs_high();
      check("R5 partial bits", r, wa >> (16 - m));
      check("R5 dropped", count, 1);
      cs_low(); send_byte(8'h40); read_bits(16, r); cs_high();
      check("R5 next entry intact", r, wb);
    end

    // R6 stop exactly at the byte boundary
    clear_frame();
    push(pat(60)); push(pat(61));
    wa = {4'b0, pat(60)};
    cs_low(); send_byte(8'h40); read_bits(8, r); cs_high();
    check("R6 high byte", r, {8'h00, wa[15:8]});
    check("R6 kept", count, 2);
    cs_low(); send_byte(8'h40); read_bits(8, r); read_bits(16, r2); cs_high();
    check("R6 low byte", r, {8'h00, wa[7:0]});
    check("R6 next entry", r2, {4'b0, pat(61)});

    // R7 empty read
    clear_frame();
    cs_low(); send_byte(8'h40); read_bits(16, r); cs_high();
    check("R7 zeros", r, 0);
    push(pat(70));
    cs_low(); send_byte(8'h40); read_bits(16, r); cs_high();
    check("R7 first entry after empty", r, {4'b0, pat(70)});

    // R8 overflow drop
    clear_frame();
    for (int i = 0; i < DEPTH + 2; i++) push(pat(40 + i));
    check("R8 count full", count, DEPTH);
    check("R8 full flag", full, 1);
    cs_low(); send_byte(8'h40);
    for (int i = 0; i < DEPTH; i++) begin
      read_bits(16, r);
      check("R8 kept order", r, {4'b0, pat(40 + i)});
    end
    cs_high();
    // R8 push meeting a removal on a full queue
    clear_frame();
    for (int i = 0; i < DEPTH; i++) push(pat(50 + i));
    push_valid = 1'b1; push_data = 12'hD3E;
    cs_low(); send_byte(8'h40); read_bits(16, r); cs_high();
    push_valid = 1'b0; tick(2);
    check("R8 head read", r, {4'b0, pat(50)});
    check("R8 refilled", count, DEPTH);
    cs_low(); send_byte(8'h40);
    for (int i = 1; i < DEPTH; i++) begin
      read_bits(16, r);
      check("R8 older entries", r, {4'b0, pat(50 + i)});
    end
    read_bits(16, r);
    check("R8 same-cycle push", r, 16'h0D3E);
    cs_high();

    // R2 full writes, extra bits ignored
    for (int g = 0; g < NREG; g++) begin
      write_frame(g, {8'h3C ^ 8'(g * 8'h11), 8'h00}, 8);
      check("R2 reg write", regs[g*REG_W +: REG_W], 8'h3C ^ 8'(g * 8'h11));
    end
    write_frame(2, 16'hA5F0, 12);
    check("R2 extra bits ignored", regs[2*REG_W +: REG_W], 8'hA5);
    check("R2 neighbour intact", regs[3*REG_W +: REG_W], 8'h3C ^ 8'h33);

    // R3 partial writes
    old_v = 8'h5A; new_v = 8'hC3;
    for (int k = 0; k < 8; k++) begin
      write_frame(1, {old_v, 8'h00}, 8);
      write_frame(1, {new_v, 8'h00}, k);
      msk = 8'(8'hFF << (8 - k));
      check("R3 partial write", regs[REG_W +: REG_W], (new_v & msk) | (old_v & ~msk));
    end

    // R9 corrupt flag
    clear_frame();
    conv_idle = 1'b0; cs_low(); conv_idle = 1'b1; cs_high();
    check("R9 corrupt set", corrupt, 1);
    cs_low(); send_byte(8'h40); read_bits(8, r); cs_high();
    check("R9 corrupt sticky", corrupt, 1);

    // R10 clear command
    push(pat(80)); push(pat(81));
    cs_low(); send_byte(8'h40); read_bits(5, r); cs_high();
    clear_frame();
    check("R10 corrupt cleared", corrupt, 0);
    check("R10 emptied", {count, empty}, {CNT_W'(0), 1'b1});
    push(pat(82));
    cs_low(); send_byte(8'h40); read_bits(16, r); cs_high();
    check("R10 cursor rewound", r, {4'b0, pat(82)});

    // R12 unknown command
    push(pat(90));
    snap = regs;
    cs_low(); send_byte(8'h1F);
    begin
      logic o;
      r = '0;
      for (int i = 0; i < 16; i++) begin
        shift(1'b1, o);
        r = {r[14:0], o};
      end
    end
    cs_high();
    check("R12 miso quiet", r, 0);
    check("R12 count kept", count, 1);
    check("R12 regs kept", regs, snap);
    cs_low(); send_byte(8'h40); read_bits(16, r); cs_high();
    check("R12 entry untouched", r, {4'b0, pat(90)});

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule